// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block steps through the elements of a single vector instruction, one index at a time. A start pulse loads the vector length, the resume index, a predicate selector and three candidate mask words. It also loads the base register numbers of one source and one destination operand, each flagged as scalar or vector. The sequencer then walks the indices from the resume index upward and stops below the length. For each index it works out whether the element is active. An active element is issued as a request that carries the index, the two register numbers and a destination write-enable bit. The sequencer then waits for the execution side to answer with a done or a trap.

Two predication styles are selectable. In single predication one mask gates the whole element. In twin predication the source side and the destination side each get their own mask. When a predicate governs a scalar operand, the loop stops at the first element whose predicate is true. This gives splat and select behaviour. A trap aborts the loop and records the failing index in the resume register, so a later start can continue from that point. A loop that completes clears the resume register to zero.

Top module: `vec_elem_seq`

## Requirements
- R1: After synchronous reset, busy, req_valid, done and trap are low and vstart is 0.
- R2: start is taken only while busy is low. From the edge that takes a non-empty start, busy stays high until the edge that raises done or trap. A start pulse seen while busy has no effect on the request stream or the result, and req_valid is only high while busy is high.
- R3: Requests are issued for ascending indices that begin at vstart_in and stay below vl. req_idx carries the element index.
- R4: If an operand's vector flag is 0, its request register number equals its base on every element. If the flag is 1, the register number equals base plus the element index, modulo 2^RW.
- R5: Single predication (twin=0): pcode 000 and 001 are unpredicated. pcode[2:1] = 01, 10 and 11 select mask_p1, mask_p2 and mask_p3. If pcode[0] is 1, the element is active where the selected mask bit is 1. If pcode[0] is 0, it is active where that bit is 0.
- R6: Twin predication (twin=1): pcode[0] enables a source predicate from mask_p1, and pcode[1] enables a destination predicate from mask_p2. pcode[2] inverts both. A disabled side is always true, so code 100 is unpredicated.
- R7: An element whose source predicate is false is skipped without a request, and the skip costs one cycle. An issued element costs two cycles plus any cycles the response is delayed. done or trap therefore appears 1 + skips + 2*issued cycles after the start edge when responses come at once.
- R8: If an enabled predicate side is true on an element and that side's operand is scalar, the loop ends after that element.
- R9: When the loop ends without a trap, done pulses for one cycle and vstart becomes 0.
- R10: An elem_trap response pulses trap for one cycle, sets vstart to the trapping element's index, and stops the loop with no further requests. elem_trap has priority over elem_done.
- R11: If vstart_in >= vl (this includes vl = 0), done pulses one cycle after start, no request is issued, busy stays low and vstart becomes 0.
- R12: req_valid and the request fields hold steady until elem_done or elem_trap arrives.
- R13: req_wen equals the destination predicate of the element: the shared predicate in single mode, the destination side in twin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop (taken only when idle) |
| vl | input | IW | Vector length, 0..MAXVL |
| vstart_in | input | IW | Index to start or resume at |
| twin | input | 1 | 1 selects twin predication |
| pcode | input | 3 | Predicate selector code |
| mask_p1 | input | MAXVL | First candidate mask |
| mask_p2 | input | MAXVL | Second candidate mask |
| mask_p3 | input | MAXVL | Third candidate mask |
| src_vec | input | 1 | Source operand is a vector |
| dst_vec | input | 1 | Destination operand is a vector |
| src_base | input | RW | Source base register number |
| dst_base | input | RW | Destination base register number |
| elem_done | input | 1 | Current element finished |
| elem_trap | input | 1 | Current element trapped |
| busy | output | 1 | Loop in progress |
| req_valid | output | 1 | Element request outstanding |
| req_idx | output | IW | Element index of the request |
| req_src | output | RW | Source register number |
| req_dst | output | RW | Destination register number |
| req_wen | output | 1 | Destination write enable |
| done | output | 1 | One-cycle loop completion pulse |
| trap | output | 1 | One-cycle trap abort pulse |
| vstart | output | IW | Resume index register |

## Verification
The bench sweeps both predication styles across all eight selector codes and all four scalar/vector operand pairings. It uses three mask sets, one of which holds all-zero and all-one words, together with length and resume pairs that include empty loops and loops of a single element. Comparing the request stream with a model separates a wrong mask choice or a wrong polarity, and an index advance on a scalar operand. Comparing the cycle counts tells a skipped element apart from an issued one. A missing stop on a scalar predicate shows up as extra requests. Directed runs trap at different positions to check the resume index, delay the responses to check that requests are held, and pulse start mid-loop to check that it is ignored.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic src_ok;  // element issues when true
    logic dst_ok;  // destination write enable
    logic halt;    // a predicate on a scalar operand fired
  } elem_pred_t;
endpackage

// File: rtl/vseq_pred_eval.sv
module vseq_pred_eval
  import vseq_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int MW = $clog2(MAXVL)
) (
  input  logic             twin,
  input  logic [2:0]       code,
  input  logic [MAXVL-1:0] m1,
  input  logic [MAXVL-1:0] m2,
  input  logic [MAXVL-1:0] m3,
  input  logic [MW-1:0]    pos,
  input  logic             src_vec,
  input  logic             dst_vec,
  output elem_pred_t       res
);
  logic b1, b2, b3, pick, s_act, d_act, s_ok, d_ok;

  assign b1 = m1[pos];
  assign b2 = m2[pos];
  assign b3 = m3[pos];

  always_comb begin
    pick  = 1'b1;
    s_act = 1'b0;
    d_act = 1'b0;
    s_ok  = 1'b1;
    d_ok  = 1'b1;
    if (twin) begin
      s_act = code[0];
      d_act = code[1];
      s_ok  = !s_act || (b1 ^ code[2]);
      d_ok  = !d_act || (b2 ^ code[2]);
    end else begin
      unique case (code[2:1])
        2'b01:   pick = b1;
        2'b10:   pick = b2;
        2'b11:   pick = b3;
        default: pick = 1'b1;
      endcase
      s_act = |code[2:1];
      d_act = s_act;
      s_ok  = !s_act || (pick == code[0]);
      d_ok  = s_ok;
    end
    res.src_ok = s_ok;
    res.dst_ok = d_ok;
    res.halt   = (s_act && !src_vec && s_ok) || (d_act && !dst_vec && d_ok);
  end
endmodule

// File: rtl/vseq_regnum.sv
module vseq_regnum #(
  parameter int IW = 7,
  parameter int RW = 7
) (
  input  logic          is_vec,
  input  logic [RW-1:0] base,
  input  logic [IW-1:0] idx,
  output logic [RW-1:0] num
);
  assign num = is_vec ? base + RW'(idx) : base;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int RW = 7,
  localparam int IW = $clog2(MAXVL + 1),
  localparam int MW = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IW-1:0]    vl,
  input  logic [IW-1:0]    vstart_in,
  input  logic             twin,
  input  logic [2:0]       pcode,
  input  logic [MAXVL-1:0] mask_p1,
  input  logic [MAXVL-1:0] mask_p2,
  input  logic [MAXVL-1:0] mask_p3,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic [RW-1:0]    src_base,
  input  logic [RW-1:0]    dst_base,
  input  logic             elem_done,
  input  logic             elem_trap,
  output logic             busy,
  output logic             req_valid,
  output logic [IW-1:0]    req_idx,
  output logic [RW-1:0]    req_src,
  output logic [RW-1:0]    req_dst,
  output logic             req_wen,
  output logic             done,
  output logic             trap,
  output logic [IW-1:0]    vstart
);
  seq_state_e           state_q;
  logic [IW-1:0]        idx_q, vl_q, idx_nx;
  logic                 twin_q, halt_q, last;
  logic [2:0]           code_q;
  logic [MAXVL-1:0]     m1_q, m2_q, m3_q;
  logic [1:0]           vec_q;
  logic [1:0][RW-1:0]   base_q;
  logic [1:0][RW-1:0]   num;
  elem_pred_t           pr;

  assign idx_nx = idx_q + IW'(1);
  assign last   = idx_nx >= vl_q;

  vseq_pred_eval #(.MAXVL(MAXVL)) u_pred (
    .twin(twin_q), .code(code_q), .m1(m1_q), .m2(m2_q), .m3(m3_q),
    .pos(idx_q[MW-1:0]), .src_vec(vec_q[0]), .dst_vec(vec_q[1]), .res(pr)
  );

  for (genvar g = 0; g < 2; g++) begin : g_op
    vseq_regnum #(.IW(IW), .RW(RW)) u_num (
      .is_vec(vec_q[g]), .base(base_q[g]), .idx(idx_q), .num(num[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      vl_q      <= '0;
      twin_q    <= 1'b0;
      code_q    <= '0;
      m1_q      <= '0;
      m2_q      <= '0;
      m3_q      <= '0;
      vec_q     <= '0;
      base_q    <= '0;
      halt_q    <= 1'b0;
      busy      <= 1'b0;
      req_valid <= 1'b0;
      req_idx   <= '0;
      req_src   <= '0;
      req_dst   <= '0;
      req_wen   <= 1'b0;
      done      <= 1'b0;
      trap      <= 1'b0;
      vstart    <= '0;
    end else begin
      done <= 1'b0;
      trap <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (vstart_in >= vl) begin
              done   <= 1'b1;
              vstart <= '0;
            end else begin
              idx_q     <= vstart_in;
              vl_q      <= vl;
              twin_q    <= twin;
              code_q    <= pcode;
              m1_q      <= mask_p1;
              m2_q      <= mask_p2;
              m3_q      <= mask_p3;
              vec_q     <= {dst_vec, src_vec};
              base_q[0] <= src_base;
              base_q[1] <= dst_base;
              busy      <= 1'b1;
              state_q   <= ST_EVAL;
            end
          end
        end
        ST_EVAL: begin
          if (pr.src_ok) begin
            req_valid <= 1'b1;
            req_idx   <= idx_q;
            req_src   <= num[0];
            req_dst   <= num[1];
            req_wen   <= pr.dst_ok;
            halt_q    <= pr.halt;
            state_q   <= ST_WAIT;
          end else if (pr.halt || last) begin
            done    <= 1'b1;
            vstart  <= '0;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_nx;
          end
        end
        ST_WAIT: begin
          if (elem_trap) begin
            req_valid <= 1'b0;
            trap      <= 1'b1;
            vstart    <= idx_q;
            busy      <= 1'b0;
            state_q   <= ST_IDLE;
          end else if (elem_done) begin
            req_valid <= 1'b0;
            if (halt_q || last) begin
              done    <= 1'b1;
              vstart  <= '0;
              busy    <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_nx;
              state_q <= ST_EVAL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst) req_valid |-> busy); // R2
  AST_BUSY_ENDS_WITH_EVENT: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (done || trap)); // R2
  AST_IDX_BELOW_VL: assert property (@(posedge clk) disable iff (rst) req_valid |-> (req_idx < vl_q)); // R3
  AST_SCALAR_SRC_FIXED: assert property (@(posedge clk) disable iff (rst) (req_valid && !vec_q[0]) |-> (req_src == base_q[0])); // R4
  AST_DONE_CLEARS_VSTART: assert property (@(posedge clk) disable iff (rst) done |-> (vstart == '0)); // R9
  AST_TRAP_RECORDS_IDX: assert property (@(posedge clk) disable iff (rst) trap |-> (vstart == req_idx && !req_valid)); // R10
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(done && trap)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !elem_done && !elem_trap) |=> (req_valid && $stable(req_idx) && $stable(req_src) && $stable(req_dst) && $stable(req_wen))); // R12
endmodule

// File: tb/sim_vec_elem_seq.sv
`timescale 1ns/1ps
module sim_vec_elem_seq;
  localparam int MAXVL = 8;
  localparam int RW = 7;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, twin, src_vec, dst_vec, elem_done, elem_trap;
  logic [IW-1:0] vl, vstart_in;
  logic [2:0] pcode;
  logic [MAXVL-1:0] mask_p1, mask_p2, mask_p3;
  logic [RW-1:0] src_base, dst_base;
  logic busy, req_valid, req_wen, done, trap;
  logic [IW-1:0] req_idx, vstart;
  logic [RW-1:0] req_src, req_dst;

  vec_elem_seq #(.MAXVL(MAXVL), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .vstart_in(vstart_in),
    .twin(twin), .pcode(pcode), .mask_p1(mask_p1), .mask_p2(mask_p2), .mask_p3(mask_p3),
    .src_vec(src_vec), .dst_vec(dst_vec), .src_base(src_base), .dst_base(dst_base),
    .elem_done(elem_done), .elem_trap(elem_trap), .busy(busy), .req_valid(req_valid),
    .req_idx(req_idx), .req_src(req_src), .req_dst(req_dst), .req_wen(req_wen),
    .done(done), .trap(trap), .vstart(vstart)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc_all = 0;

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 200000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 200000", cyc_all);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // predicate model taken from R5, R6 and R8
  function automatic bit src_ok(input int i);
    bit b;
    if (twin) return !pcode[0] || (mask_p1[i[2:0]] ^ pcode[2]);
    if (pcode[2:1] == 2'b00) return 1'b1;
    b = (pcode[2:1] == 2'b01) ? mask_p1[i[2:0]] :
        (pcode[2:1] == 2'b10) ? mask_p2[i[2:0]] : mask_p3[i[2:0]];
    return b == pcode[0];
  endfunction

  function automatic bit dst_ok(input int i);
    if (twin) return !pcode[1] || (mask_p2[i[2:0]] ^ pcode[2]);
    return src_ok(i);
  endfunction

  function automatic bit halts(input int i);
    bit sa, da;
    sa = twin ? pcode[0] : (pcode[2:1] != 2'b00);
    da = twin ? pcode[1] : sa;
    return (sa && !src_vec && src_ok(i)) || (da && !dst_vec && dst_ok(i));
  endfunction

  task automatic run(input int vl_v, input int vs_v, input int trap_ord, input int lag, input bit poke);
    int e_idx[MAXVL];
    bit e_wen[MAXVL];
    int ne, skips, e_vs, cyc, n, exp_cyc;
    bit e_trap, fin;
    ne = 0; skips = 0; e_vs = 0; e_trap = 0;
    @(negedge clk);
    vl = IW'(vl_v);
    vstart_in = IW'(vs_v);
    if (vs_v < vl_v) begin
      for (int i = vs_v; i < vl_v; i++) begin
        if (src_ok(i)) begin
          e_idx[ne] = i;
          e_wen[ne] = dst_ok(i);
          ne++;
          if (ne - 1 == trap_ord) begin
            e_trap = 1;
            e_vs = i;
            break;
          end
        end else skips++;
        if (halts(i)) break;
      end
    end
    exp_cyc = 1 + skips + (2 + lag) * ne;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; n = 0; fin = 0;
    while (!fin && cyc < 120) begin
      if (done || trap) fin = 1;
      else begin
        if (req_valid) begin
          if (n >= ne) chk(0, "R8", "extra request index", int'(req_idx), -1);
          else begin
            chk(int'(req_idx) == e_idx[n], "R3", "req_idx", int'(req_idx), e_idx[n]);
            chk(int'(req_src) == ((int'(src_base) + (src_vec ? e_idx[n] : 0)) % 128), "R4", "req_src",
                int'(req_src), (int'(src_base) + (src_vec ? e_idx[n] : 0)) % 128);
            chk(int'(req_dst) == ((int'(dst_base) + (dst_vec ? e_idx[n] : 0)) % 128), "R4", "req_dst",
                int'(req_dst), (int'(dst_base) + (dst_vec ? e_idx[n] : 0)) % 128);
            chk(req_wen == e_wen[n], "R13", "req_wen", int'(req_wen), int'(e_wen[n]));
          end
          for (int k = 0; k < lag; k++) begin
            @(negedge clk);
            cyc++;
            chk(req_valid && n < ne && int'(req_idx) == e_idx[n], "R12", "held request index",
                int'(req_idx), (n < ne) ? e_idx[n] : -1);
          end
          if (n == trap_ord) elem_trap = 1'b1;
          else elem_done = 1'b1;
          if (poke && n == 0) begin
            start = 1'b1;
            vstart_in = '0;
          end
          n++;
        end
        @(negedge clk);
        elem_done = 1'b0;
        elem_trap = 1'b0;
        start = 1'b0;
        cyc++;
      end
    end
    chk(fin, "R9", "loop ended", int'(fin), 1);
    chk(trap == e_trap && done == !e_trap, "R10", "trap flag", int'(trap), int'(e_trap));
    chk(cyc == exp_cyc, "R7", "cycles to end", cyc, exp_cyc);
    chk(int'(vstart) == e_vs, "R9", "vstart", int'(vstart), e_vs);
    chk(n == ne, "R3", "request count", n, ne);
    chk(!busy, "R2", "busy at end", int'(busy), 0);
    @(negedge clk);
    chk(!done && !trap, "R9", "end pulse width", int'(done) + int'(trap), 0);
  endtask

  initial begin
    int pairs[6][2];
    logic [MAXVL-1:0] ms[3][3];
    pairs = '{'{8, 0}, '{5, 2}, '{8, 7}, '{0, 0}, '{3, 3}, '{2, 5}};
    ms = '{'{8'hA5, 8'h3C, 8'hF0}, '{8'h00, 8'hFF, 8'h81}, '{8'h6E, 8'h12, 8'h9B}};
    rst = 1; start = 0; twin = 0; pcode = 0; src_vec = 1; dst_vec = 1;
    elem_done = 0; elem_trap = 0; vl = 0; vstart_in = 0;
    mask_p1 = 0; mask_p2 = 0; mask_p3 = 0; src_base = 7'd125; dst_base = 7'd3;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !req_valid && !done && !trap && vstart == 0, "R1", "reset state",
        int'(busy) + int'(req_valid) + int'(done) + int'(trap) + int'(vstart), 0);

    // R11 empty loops
    run(0, 0, -1, 0, 0);
    run(4, 4, -1, 0, 0);

    // R5 R6 R8 sweep over codes, operand kinds, masks and ranges
    for (int md = 0; md < 2; md++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 4; f++)
          for (int s = 0; s < 3; s++)
            for (int p = 0; p < 6; p++) begin
              twin = md[0];
              pcode = c[2:0];
              src_vec = f[0];
              dst_vec = f[1];
              mask_p1 = ms[s][0];
              mask_p2 = ms[s][1];
              mask_p3 = ms[s][2];
              run(pairs[p][0], pairs[p][1], -1, 0, 0);
            end

    // R10 trap at various positions, then resume from recorded index
    twin = 0; pcode = 3'b000; src_vec = 1; dst_vec = 1;
    for (int t = 0; t < 4; t++) run(8, 1, t, 0, 0);
    run(8, 4, -1, 0, 0);
    pcode = 3'b011; mask_p1 = 8'h5A;
    for (int t = 0; t < 3; t++) run(8, 0, t, 0, 0);

    // R12 delayed responses
    pcode = 3'b000;
    run(6, 1, -1, 2, 0);
    run(6, 0, 1, 3, 0);

    // R2 start pulse while busy is ignored
    run(7, 2, -1, 0, 1);
    twin = 1; pcode = 3'b011; src_vec = 0; mask_p1 = 8'h04; mask_p2 = 8'hFF;
    run(8, 0, -1, 0, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule